// File: doc/BRIEF.md
# Sync-Realigned Clock Divider

This block divides a fast clock by a programmable integer modulus and lets an external SYNC line re-phase the divided output. When sync control is enabled, the edge of SYNC opposite to the programmed one starts an orderly halt. The divided clock finishes its current high phase and then parks low. The programmed edge restarts the divider from count zero, so the output phase follows that edge plus a fixed latency.

When sync control is disabled, the divider runs freely and SYNC has no effect. A status output reads 1 while the output is parked. SYNC is taken through a two-stage synchronizer clocked by the fast clock. An edge detector sits behind it, so the restart latency is the same on every restart.

Top module: `clkresync_top`

## Requirements
- R1: While reset is asserted (rstN low), and on release, clkOut is 0 and stopped is 0.
- R2: With syncEn at 0, clkOut is periodic with a period of divMod fast cycles. It is high for divMod - floor(divMod/2) cycles and then low for the rest (divMod >= 2).
- R3: With syncEn at 0, SYNC transitions have no effect: stopped stays 0 and the clkOut period is unchanged.
- R4: syncPol selects the restart (active) SYNC edge. A value of 1 selects the rising edge and 0 selects the falling edge. The opposite edge is the halt edge.
- R5: With syncEn at 1, a halt edge on SYNC parks clkOut low and sets stopped to 1 within 2*divMod + 4 fast cycles. Both stay there until a restart edge arrives.
- R6: No high pulse of clkOut is ever shortened. Every high phase lasts exactly divMod - floor(divMod/2) fast cycles, including the last one before a halt.
- R7: After SYNC changes to its active level between two rising fast-clock edges, stopped falls on the 3rd rising edge after the change. clkOut rises on the 4th rising edge.
- R8: After a restart, the divider counts from zero. The next rising edge of clkOut comes exactly divMod cycles after the first one.
- R9: Clearing syncEn while parked releases the divider. stopped falls on the next rising edge, and clkOut rises on the edge after that.
- R10: stopped only rises when syncEn was 1 in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Asynchronous reset, active low |
| syncIn | input | 1 | External SYNC line, asynchronous |
| syncEn | input | 1 | 1 enables halt/restart under SYNC control |
| syncPol | input | 1 | Active SYNC edge: 1 rising, 0 falling |
| divMod | input | DIV_W | Divider modulus, 2 or more |
| clkOut | output | 1 | Divided, gated output clock |
| stopped | output | 1 | 1 while the output is parked low |

## Verification
The hardest situation to reach from the ports is a halt edge that lands in the middle of a high phase. That is where a careless design would clip the pulse. The bench sends halt edges at several offsets into the output period for odd and even moduli. A bound checker measures the length of every high pulse, so a clipped final pulse is caught whatever its offset. Restarts are timed against the cycle in which SYNC was driven, which checks the fixed latency and the realigned phase together.

// File: rtl/clkresync_pkg.sv
package clkresync_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic hold;     // force counter to zero and output low
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_HALT  = 2'd2
  } ctlState_t;

endpackage

// File: rtl/clkresync_ctrl.sv
module clkresync_ctrl
  import clkresync_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  input  logic       syncEn,
  input  logic       syncPol,
  input  logic       lowPhase,
  output ctlStrobe_t strobe,
  output logic       stopped
);

  localparam int CHAIN_LEN = SYNC_STAGES + 1;

  logic [CHAIN_LEN-1:0] syncChain;
  logic      normNow, normPrev;
  logic      activeEdge, haltEdge;
  ctlState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[CHAIN_LEN-2:0], syncIn};
  end

  // normalise so that a rising normalised level is always the restart edge
  assign normNow    = syncPol ? syncChain[CHAIN_LEN-2] : ~syncChain[CHAIN_LEN-2];
  assign normPrev   = syncPol ? syncChain[CHAIN_LEN-1] : ~syncChain[CHAIN_LEN-1];
  assign activeEdge = normNow & ~normPrev;
  assign haltEdge   = ~normNow & normPrev;

  always_comb begin
    stateNext = state;
    if (!syncEn) begin
      stateNext = ST_RUN;
    end else begin
      unique case (state)
        ST_RUN:   if (haltEdge) stateNext = ST_DRAIN;
        ST_DRAIN: begin
          if (activeEdge)    stateNext = ST_RUN;
          else if (lowPhase) stateNext = ST_HALT;
        end
        ST_HALT:  if (activeEdge) stateNext = ST_RUN;
        default:  stateNext = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  assign strobe.hold = (state == ST_HALT);
  assign stopped     = (state == ST_HALT);

endmodule

// File: rtl/clkresync_dp.sv
module clkresync_dp
  import clkresync_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divMod,
  input  ctlStrobe_t       strobe,
  output logic             lowPhase,
  output logic             clkOut
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] highLen;
  logic [DIV_W-1:0] lastCnt;

  assign highLen  = divMod - (divMod >> 1);
  assign lastCnt  = divMod - 1'b1;
  assign lowPhase = (cnt >= highLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      clkOut <= 1'b0;
    end else if (strobe.hold) begin
      cnt    <= '0;
      clkOut <= 1'b0;
    end else begin
      cnt    <= (cnt >= lastCnt) ? '0 : cnt + 1'b1;
      clkOut <= (cnt < highLen);
    end
  end

endmodule

// File: rtl/clkresync_top.sv
module clkresync_top
  import clkresync_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic             syncEn,
  input  logic             syncPol,
  input  logic [DIV_W-1:0] divMod,
  output logic             clkOut,
  output logic             stopped
);

  ctlStrobe_t strobe;
  logic       lowPhase;

  clkresync_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .syncIn   (syncIn),
    .syncEn   (syncEn),
    .syncPol  (syncPol),
    .lowPhase (lowPhase),
    .strobe   (strobe),
    .stopped  (stopped)
  );

  clkresync_dp #(.DIV_W(DIV_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .divMod   (divMod),
    .strobe   (strobe),
    .lowPhase (lowPhase),
    .clkOut   (clkOut)
  );

endmodule

// File: rtl/clkresync_checker.sv
module clkresync_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             syncEn,
  input logic [DIV_W-1:0] divMod,
  input logic             clkOut,
  input logic             stopped
);

  logic [DIV_W-1:0] highRun;
  logic [DIV_W-1:0] expHigh;

  assign expHigh = divMod - (divMod >> 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       highRun <= '0;
    else if (clkOut) highRun <= highRun + 1'b1;
    else             highRun <= '0;
  end

  AST_PARK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    stopped |-> !clkOut); // R5

  AST_FULL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkOut) |-> (highRun == expHigh)); // R6

  AST_RESTART_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stopped) |=> clkOut); // R7

  AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (!syncEn && $past(!syncEn)) |-> !stopped); // R3

  AST_STOP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopped) |-> $past(syncEn)); // R10

endmodule

bind clkresync_top clkresync_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rstN(rstN), .syncEn(syncEn), .divMod(divMod),
  .clkOut(clkOut), .stopped(stopped)
);

// File: tb/tb_clkresync_top.sv
module tb_clkresync_top;

  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             syncIn = 1'b0;
  logic             syncEn = 1'b0;
  logic             syncPol = 1'b0;
  logic [DIV_W-1:0] divMod = 8'd4;
  logic             clkOut;
  logic             stopped;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // modulus, expected high time
  localparam int NVEC = 6;
  localparam int VEC [NVEC][2] = '{'{2,1}, '{3,2}, '{4,2}, '{5,3}, '{8,4}, '{13,7}};

  always #2.5 clk = ~clk;

  clkresync_top #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .syncEn(syncEn),
    .syncPol(syncPol), .divMod(divMod), .clkOut(clkOut), .stopped(stopped)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(input int m, input logic en, input logic pol, input logic lvl);
    @(negedge clk);
    rstN = 1'b0; divMod = DIV_W'(m); syncEn = en; syncPol = pol; syncIn = lvl;
    step(2);
    rstN = 1'b1;
    step(6);
  endtask

  // waits for a rising clkOut, then measures high and low lengths
  task automatic measure(output int hi, output int lo);
    int guard;
    hi = 0; lo = 0; guard = 0;
    while (clkOut && guard < 100) begin step(1); guard++; end
    while (!clkOut && guard < 200) begin step(1); guard++; end
    while (clkOut && guard < 300) begin hi++; step(1); guard++; end
    while (!clkOut && guard < 400) begin lo++; step(1); guard++; end
  endtask

  task automatic finishRun;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  // halt at a given offset into the period, then restart and check phase
  task automatic haltRestart(input int m, input logic pol, input int offset, input string tag);
    int hi, lo, waitN;
    doReset(m, 1'b1, pol, pol);
    measure(hi, lo);
    step(offset);
    syncIn = ~pol;                                    // halt edge
    step(2 * m + 4);
    chk({tag, " R5 stopped"}, int'(stopped), 1);
    chk({tag, " R5 parked low"}, int'(clkOut), 0);
    waitN = 0;
    repeat (20) begin if (clkOut || !stopped) waitN++; step(1); end
    chk({tag, " R5 stays parked"}, waitN, 0);
    syncIn = pol;                                     // restart edge
    step(2);
    chk({tag, " R7 still stopped"}, int'(stopped), 1);
    step(1);
    chk({tag, " R7 stopped falls"}, int'(stopped), 0);
    chk({tag, " R7 clkOut low"}, int'(clkOut), 0);
    step(1);
    chk({tag, " R7 clkOut rises"}, int'(clkOut), 1);
    step(m - 1);
    chk({tag, " R8 period end low"}, int'(clkOut), 0);
    step(1);
    chk({tag, " R8 next rise"}, int'(clkOut), 1);
  endtask

  initial begin
    int hi, lo;
    // R1 reset state
    @(negedge clk);
    chk("R1 clkOut in reset", int'(clkOut), 0);
    chk("R1 stopped in reset", int'(stopped), 0);
    rstN = 1'b1;
    step(1);
    chk("R1 stopped after release", int'(stopped), 0);

    // R2 free-running table
    for (int v = 0; v < NVEC; v++) begin
      doReset(VEC[v][0], 1'b0, 1'b1, 1'b0);
      measure(hi, lo);
      chk($sformatf("R2 high m=%0d", VEC[v][0]), hi, VEC[v][1]);
      chk($sformatf("R2 period m=%0d", VEC[v][0]), hi + lo, VEC[v][0]);
    end

    // R3 SYNC ignored while disabled
    doReset(5, 1'b0, 1'b1, 1'b1);
    begin
      int st = 0;
      for (int k = 0; k < 12; k++) begin
        syncIn = ~syncIn;
        step(7);
        st += int'(stopped);
      end
      chk("R3 stopped never set", st, 0);
      measure(hi, lo);
      chk("R3 period unchanged", hi + lo, 5);
    end

    // R4..R8 both polarities, odd/even moduli, several halt offsets
    haltRestart(4, 1'b1, 0, "pos m4 o0");
    haltRestart(4, 1'b1, 1, "pos m4 o1");
    haltRestart(5, 1'b0, 0, "R4 neg m5 o0");
    haltRestart(5, 1'b0, 2, "R4 neg m5 o2");
    haltRestart(7, 1'b1, 3, "R6 pos m7 o3");
    haltRestart(2, 1'b0, 1, "neg m2 o1");

    // R4 wrong-direction edge for the polarity does not halt
    doReset(4, 1'b1, 1'b1, 1'b0);
    syncIn = 1'b1;
    step(20);
    chk("R4 active edge only no halt", int'(stopped), 0);

    // R9 releasing syncEn while parked
    doReset(6, 1'b1, 1'b1, 1'b1);
    syncIn = 1'b0;
    step(20);
    chk("R9 parked first", int'(stopped), 1);
    syncEn = 1'b0;
    step(1);
    chk("R9 stopped falls", int'(stopped), 0);
    chk("R9 clkOut still low", int'(clkOut), 0);
    step(1);
    chk("R9 clkOut rises", int'(clkOut), 1);

    // R10 halt edge then enable later: no stop without enable
    doReset(4, 1'b0, 1'b1, 1'b1);
    syncIn = 1'b0;
    step(4);
    syncEn = 1'b1;
    step(20);
    chk("R10 no stop from edge seen while disabled", int'(stopped), 0);

    finishRun();
  end

endmodule